// File: doc/BRIEF.md
# Harmonic-Scaled Gate Timer

This block produces a measurement gate whose length is N periods of a selected time base. N is a harmonic number that the block measures itself each time it runs. An input pulse stream runs at N times 20 kHz. On an accepted open request, the block counts those pulses over a window of two periods of a 500 Hz tick, which is 4 ms and holds 80N pulses. A divide-by-10 stage followed by a divide-by-8 stage reduces the count to N.

The block loads the one's complement of N into an 8-bit up-counter. It opens the gate on the next time-base enable. The gate closes on the enable that arrives while the counter reads 254, which is the Nth enable after opening. If N is zero or does not fit in eight bits, the block pulses an error output and leaves the gate closed.

Top module: `harmonic_gate_timer`

## Requirements
- R1: After reset, gate, busy and n_err are all low.
- R2: An open_req sampled high while idle makes busy high from the next cycle. Busy stays high until the gate closes or an error is reported.
- R3: open_req has no effect while busy is high. The run in progress keeps its timing, and no second run follows it.
- R4: The window starts at the first win_tick after a request is accepted and ends at the second win_tick after that. harm_pulse is counted in the cycle of the ending tick but not in the cycle of the starting tick, nor before it.
- R5: The measured N is the floor of the window pulse count divided by 80, so remainders of up to 79 pulses are dropped.
- R6: If N is 0, n_err is high for exactly one cycle, busy falls on that same edge, and the gate never opens.
- R7: If N exceeds 255, for example 20480 pulses giving 256, the outcome is the same as in R6.
- R8: After the measurement the gate rises on the first tb_en edge. Enables before the measurement ends do not open it.
- R9: The gate stays high for exactly N tb_en periods and falls on the Nth tb_en after the opening one. For N=22 the counter is preset to 233.
- R10: Busy falls on the same edge as the gate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| open_req | input | 1 | Request to run one gate cycle |
| harm_pulse | input | 1 | One-cycle enable per pulse of the N x 20 kHz stream |
| win_tick | input | 1 | One-cycle enable at 500 Hz |
| tb_en | input | 1 | One-cycle enable per selected time-base period |
| gate | output | 1 | Main gate level |
| busy | output | 1 | High from request acceptance to completion |
| n_err | output | 1 | One-cycle pulse when N is 0 or above 255 |

## Verification
The bench builds the block with its default parameters: divisors 10 and 8, an 8-bit counter and a two-tick window. It drives the window ticks itself, so a 4 ms window can hold any number of pulses. This brings into reach the extreme values of N, which are 1 and 255, along with the invalid counts 79 and 20480. It also covers remainders just below the next multiple of 80. A time base with a period of four clocks makes the gate width a direct multiple of N.

// File: rtl/harmonic_gate_timer.sv
module harmonic_gate_timer #(
  parameter int DIV_A     = 10,
  parameter int DIV_B     = 8,
  parameter int CW        = 8,
  parameter int WIN_TICKS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic open_req,
  input  logic harm_pulse,
  input  logic win_tick,
  input  logic tb_en,
  output logic gate,
  output logic busy,
  output logic n_err
);
  localparam int AW = $clog2(DIV_A);
  localparam int BW = $clog2(DIV_B);
  localparam int WW = $clog2(WIN_TICKS + 1);
  localparam logic [CW-1:0] N_MAX   = {CW{1'b1}};
  localparam logic [CW-1:0] ARM_VAL = {{(CW-1){1'b1}}, 1'b0};

  typedef enum logic [2:0] {S_IDLE, S_ARM, S_MEAS, S_CHK, S_SYNC, S_OPEN} st_t;

  st_t           st;
  logic [AW-1:0] pa;
  logic [BW-1:0] pb;
  logic [WW-1:0] wcnt;
  logic [CW-1:0] nacc;
  logic          ovf;
  logic [CW-1:0] cnt;

  wire pa_wrap = (pa == AW'(DIV_A - 1));
  wire pb_wrap = (pb == BW'(DIV_B - 1));
  wire win_end = win_tick && (wcnt == WW'(WIN_TICKS - 1));
  wire n_bad   = (nacc == '0) || ovf;

  assign busy = (st != S_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      pa    <= '0;
      pb    <= '0;
      wcnt  <= '0;
      nacc  <= '0;
      ovf   <= 1'b0;
      cnt   <= '0;
      gate  <= 1'b0;
      n_err <= 1'b0;
    end else begin
      n_err <= 1'b0;
      case (st)
        S_IDLE: if (open_req) st <= S_ARM;
        S_ARM: if (win_tick) begin
          st   <= S_MEAS;
          pa   <= '0;
          pb   <= '0;
          wcnt <= '0;
          nacc <= '0;
          ovf  <= 1'b0;
        end
        S_MEAS: begin
          if (harm_pulse) begin
            pa <= pa_wrap ? '0 : pa + 1'b1;
            if (pa_wrap) begin
              pb <= pb_wrap ? '0 : pb + 1'b1;
              if (pb_wrap) begin
                if (nacc == N_MAX) ovf <= 1'b1;
                else nacc <= nacc + 1'b1;
              end
            end
          end
          if (win_tick) wcnt <= wcnt + 1'b1;
          if (win_end) st <= S_CHK;
        end
        S_CHK: begin
          if (n_bad) begin
            n_err <= 1'b1;
            st    <= S_IDLE;
          end else begin
            cnt <= ~nacc;
            st  <= S_SYNC;
          end
        end
        S_SYNC: if (tb_en) begin
          gate <= 1'b1;
          st   <= S_OPEN;
        end
        S_OPEN: if (tb_en) begin
          if (cnt == ARM_VAL) begin
            gate <= 1'b0;
            st   <= S_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/gate_timer_checks.sv
module gate_timer_checks (
  input logic clk,
  input logic rst_n,
  input logic tb_en,
  input logic gate,
  input logic busy,
  input logic n_err
);
  a_r2_gate_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    gate |-> busy);
  a_r8_open_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate) |-> $past(tb_en));
  a_r9_close_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(gate) |-> $past(tb_en));
  a_r10_busy_with_gate: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(gate) |-> !busy);
  a_r6_err_single: assert property (@(posedge clk) disable iff (!rst_n)
    n_err |=> !n_err);
  a_r7_err_ends_run: assert property (@(posedge clk) disable iff (!rst_n)
    n_err |-> (!gate && !busy && $past(busy)));
endmodule

bind harmonic_gate_timer gate_timer_checks u_chk (
  .clk(clk), .rst_n(rst_n), .tb_en(tb_en),
  .gate(gate), .busy(busy), .n_err(n_err)
);

// File: tb/sim_harmonic_gate_timer.sv
module sim_harmonic_gate_timer;
  localparam int TBP = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic open_req = 1'b0, harm_pulse = 1'b0, win_tick = 1'b0, tb_en = 1'b0;
  logic gate, busy, n_err;

  int checks = 0, fails = 0;
  bit run_on = 1'b0;

  always #10 clk = ~clk;

  harmonic_gate_timer u0 (
    .clk(clk), .rst_n(rst_n), .open_req(open_req), .harm_pulse(harm_pulse),
    .win_tick(win_tick), .tb_en(tb_en), .gate(gate), .busy(busy), .n_err(n_err)
  );

  int tbc = 0;
  always @(negedge clk) begin
    tbc = (tbc + 1) % TBP;
    tb_en = (tbc == 0);
  end

  int m_st = 0, m_tot = 0, m_ticks = 0, m_left = 0, m_n = 0;
  bit m_gate = 0, m_err = 0;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_gate = 0; m_err = 0;
    end else begin
      m_err = 0;
      case (m_st)
        0: if (open_req) m_st = 1;
        1: if (win_tick) begin m_st = 2; m_tot = 0; m_ticks = 0; end
        2: begin
          if (harm_pulse) m_tot++;
          if (win_tick) begin m_ticks++; if (m_ticks == 2) m_st = 3; end
        end
        3: begin
          m_n = m_tot / 80;
          if (m_n == 0 || m_n > 255) begin m_err = 1; m_st = 0; end
          else begin m_left = m_n; m_st = 4; end
        end
        4: if (tb_en) begin m_gate = 1; m_st = 5; end
        default: if (tb_en) begin
          m_left--;
          if (m_left == 0) begin m_gate = 0; m_st = 0; end
        end
      endcase
    end
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (run_on) begin
    check("R2/R10 busy", busy, m_st != 0);
    check("R8/R9 gate", gate, m_gate);
    check("R6/R7 n_err", n_err, m_err);
  end

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  task automatic run_case(string req, int npulses, int junk, int exp_n);
    int hi = 0;
    bit seen = 0;
    @(negedge clk) open_req = 1;
    @(negedge clk) open_req = 0;
    for (int i = 0; i < junk; i++) begin
      @(negedge clk) harm_pulse = 1;
      open_req = (i == 0);
    end
    @(negedge clk) begin harm_pulse = 0; open_req = 0; win_tick = 1; end
    for (int i = 0; i < npulses; i++) begin
      @(negedge clk) harm_pulse = 1;
      win_tick = (i == npulses / 2) || (i == npulses - 1);
      open_req = (i == 3);
    end
    @(negedge clk) begin harm_pulse = 0; win_tick = 0; open_req = 0; end
    do begin
      @(negedge clk);
      hi += gate;
      seen |= n_err;
      open_req = (hi == 5);
    end while (busy);
    open_req = 0;
    if (exp_n == 0 || exp_n > 255) begin
      check({req, " error flagged"}, seen, 1);
      check({req, " gate never opened"}, hi, 0);
    end else begin
      check({req, " no error"}, seen, 0);
      check({req, " gate width cycles"}, hi, exp_n * TBP);
    end
    repeat (2 * TBP) @(negedge clk);
    check("R3 no second run", busy, 0);
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 gate", gate, 0);
    check("R1 busy", busy, 0);
    check("R1 n_err", n_err, 0);
    rst_n = 1;
    run_on = 1;
    @(negedge clk);
    run_case("R9 N=22 preset 233", 1760, 40, 22);
    run_case("R5 N=22 rem 79", 1839, 0, 22);
    run_case("R4 N=1 junk excluded", 80, 100, 1);
    run_case("R9 N=255", 20400, 5, 255);
    run_case("R6 N=0", 79, 300, 0);
    run_case("R7 N=256", 20480, 0, 256);
    run_case("R5 N=5", 479, 2, 5);
    summary();
  end
endmodule